// File: doc/BRIEF.md
# Snooping Line-State Controller

This block keeps the coherence state of every line in one processor's cache on a shared-bus multiprocessor. A direct-mapped array of tags and states records each line as absent, exclusive (no other cache holds it) or shared. The processor side takes read and write requests and answers with hit, stall and done. The bus side requests the bus and waits for a grant, then issues a read or a read-exclusive. It also watches the transactions that other caches put on the bus and changes its own line states to match.

Writes to an exclusive line finish locally with no bus traffic. Any other write is carried out as a read-exclusive followed by a local write, which leaves the line exclusive. There is no dirty or modified state. A read miss fills the line as exclusive unless another cache reports that it also holds the line, in which case the fill is shared. Snooped traffic is serviced in every cycle, including the cycles in which the processor is stalled waiting for the bus. The data array, replacement and main memory belong to other blocks.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is absent, so the first access to any address misses and stalls.
- R2: A read whose tag matches a line in the exclusive or shared state raises cpu_hit and cpu_done in the same cycle as the request. It issues no bus command and leaves the state unchanged.
- R3: A write whose tag matches an exclusive line raises cpu_hit and cpu_done in the request cycle, and bus_cmd stays 0 (idle).
- R4: A write to a shared or absent line stalls the processor. It raises bus_req and, in the grant cycle, drives bus_cmd = 2 (read-exclusive) with bus_addr equal to the request address and raises cpu_done. The line then becomes exclusive.
- R5: A read miss drives bus_cmd = 1 (read) in the grant cycle. The line fills as exclusive when bus_shared_in is low in that cycle and as shared when it is high.
- R6: A snooped read (snoop_cmd = 1) that matches a present line raises snoop_shared_out in the same cycle. An exclusive line becomes shared.
- R7: A snooped read-exclusive (snoop_cmd = 2) that matches a present line makes the line absent. snoop_shared_out stays low.
- R8: A snoop whose tag does not match, or whose line is absent, changes no state and leaves snoop_shared_out low.
- R9: While the controller waits for grant, snoops are still serviced and snoop_shared_out still responds.
- R10: bus_req stays high from the cycle after a miss until the grant. bus_cmd is non-zero only in the cycle where bus_req and bus_gnt are both high.
- R11: The line index is the low log2(LINES) bits of the address and the rest is the tag. A fill to an index replaces the line held there under a different tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_hit | output | 1 | Request served from the local state |
| cpu_stall | output | 1 | Request waiting for the bus |
| cpu_done | output | 1 | Request complete this cycle |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 read-exclusive |
| bus_addr | output | ADDR_W | Address of the issued bus command |
| bus_shared_in | input | 1 | Another cache holds the line being read |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared_out | output | 1 | This cache holds the snooped line |

## Verification
The bench builds the block with its defaults: a 10-bit address and 16 lines, which leaves a 6-bit tag. With that geometry, addresses 0x013 and 0x053 fall on the same index under different tags, so eviction and snoops that miss on the tag can be exercised on one line. Grant delays of zero to two cycles make it possible to snoop a line while a miss is waiting for the bus.

// File: rtl/snoop_coh_pkg.sv
package snoop_coh_pkg;
   typedef enum logic [1:0] {
      LN_ABSENT = 2'd0,
      LN_EXCL   = 2'd1,
      LN_SHRD   = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE  = 2'd0,
      BC_READ  = 2'd1,
      BC_READX = 2'd2
   } bus_cmd_e;
endpackage

// File: rtl/snoop_coh_tags.sv
module snoop_coh_tags
   import snoop_coh_pkg::*;
#(
   parameter int LINES = 16,
   parameter int TAG_W = 6,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  line_st_e         fill_st,
   input  logic             snp_en,
   input  logic [IDX_W-1:0] snp_idx,
   input  line_st_e         snp_st,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic [TAG_W-1:0] rd_a_tag,
   output line_st_e         rd_a_st,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic [TAG_W-1:0] rd_b_tag,
   output line_st_e         rd_b_st
);
   logic [TAG_W-1:0] tag_v [LINES];
   line_st_e         st_v  [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      logic [TAG_W-1:0] tag_r;
      line_st_e         st_r;
      // own fill wins over a snoop to the same index (the bus is ours then)
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_r <= '0;
            st_r  <= LN_ABSENT;
         end else if (fill_en && fill_idx == MY_IDX) begin
            tag_r <= fill_tag;
            st_r  <= fill_st;
         end else if (snp_en && snp_idx == MY_IDX) begin
            st_r  <= snp_st;
         end
      end
      assign tag_v[i] = tag_r;
      assign st_v[i]  = st_r;
   end

   assign rd_a_tag = tag_v[rd_a_idx];
   assign rd_a_st  = st_v[rd_a_idx];
   assign rd_b_tag = tag_v[rd_b_idx];
   assign rd_b_st  = st_v[rd_b_idx];

   // R1: the storage comes out of reset with every line absent
   assert property (@(posedge clk) $rose(rst_n) |-> rd_a_st == LN_ABSENT && rd_b_st == LN_ABSENT)
      else $error("assert_reset_absent_R1");
endmodule

// File: rtl/snoop_coh_snoop.sv
module snoop_coh_snoop
   import snoop_coh_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snoop_valid,
   input  logic [1:0]       snoop_cmd,
   input  logic [TAG_W-1:0] snoop_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_st,
   output logic             upd_en,
   output line_st_e         upd_st,
   output logic             shared_resp
);
   logic present;
   logic is_rd;
   logic is_rdx;

   assign present = (line_st != LN_ABSENT) && (line_tag == snoop_tag);
   assign is_rd   = snoop_valid && snoop_cmd == BC_READ;
   assign is_rdx  = snoop_valid && snoop_cmd == BC_READX;

   always_comb begin
      upd_en = 1'b0;
      upd_st = LN_SHRD;
      if (present && is_rdx) begin
         upd_en = 1'b1;
         upd_st = LN_ABSENT;
      end else if (present && is_rd && line_st == LN_EXCL) begin
         upd_en = 1'b1;
         upd_st = LN_SHRD;
      end
   end

   assign shared_resp = present && is_rd;

   // R7: a read-exclusive never draws a shared response
   assert property (@(posedge clk) disable iff (!rst_n) is_rdx |-> !shared_resp)
      else $error("assert_rdx_no_share_R7");
   // R8: no state update without a matching present line
   assert property (@(posedge clk) disable iff (!rst_n)
                    (line_st == LN_ABSENT || line_tag != snoop_tag) |-> !upd_en && !shared_resp)
      else $error("assert_miss_untouched_R8");
endmodule

// File: rtl/snoop_coh_req.sv
module snoop_coh_req
   import snoop_coh_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [TAG_W-1:0] cpu_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_st,
   input  logic             bus_gnt,
   input  logic             bus_shared_in,
   output logic             cpu_hit,
   output logic             cpu_stall,
   output logic             cpu_done,
   output logic             bus_req,
   output logic [1:0]       bus_cmd,
   output logic             fill_en,
   output line_st_e         fill_st
);
   typedef enum logic {S_IDLE, S_WAIT} req_st_e;
   req_st_e fsm_q, fsm_d;
   logic    tag_hit;

   assign tag_hit = (line_st != LN_ABSENT) && (line_tag == cpu_tag);

   always_comb begin
      fsm_d     = fsm_q;
      cpu_hit   = 1'b0;
      cpu_stall = 1'b0;
      cpu_done  = 1'b0;
      bus_req   = 1'b0;
      bus_cmd   = BC_IDLE;
      fill_en   = 1'b0;
      fill_st   = LN_EXCL;
      case (fsm_q)
         S_IDLE: begin
            if (cpu_req) begin
               if (tag_hit && (!cpu_we || line_st == LN_EXCL)) begin
                  cpu_hit  = 1'b1;
                  cpu_done = 1'b1;
               end else begin
                  cpu_stall = 1'b1;
                  fsm_d     = S_WAIT;
               end
            end
         end
         S_WAIT: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               bus_cmd  = cpu_we ? BC_READX : BC_READ;
               cpu_done = 1'b1;
               fill_en  = 1'b1;
               fill_st  = (cpu_we || !bus_shared_in) ? LN_EXCL : LN_SHRD;
               fsm_d    = S_IDLE;
            end else begin
               cpu_stall = 1'b1;
            end
         end
         default: fsm_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fsm_q <= S_IDLE;
      else        fsm_q <= fsm_d;
   end

   // R10: request held until granted
   assert property (@(posedge clk) disable iff (!rst_n) bus_req && !bus_gnt |=> bus_req)
      else $error("assert_req_held_R10");
   // R10: a command appears only in a granted cycle
   assert property (@(posedge clk) disable iff (!rst_n) bus_cmd != BC_IDLE |-> bus_req && bus_gnt)
      else $error("assert_cmd_on_grant_R10");
   // R2 / R3: a hit never touches the bus
   assert property (@(posedge clk) disable iff (!rst_n) cpu_hit |-> bus_cmd == BC_IDLE && !bus_req && cpu_done)
      else $error("assert_hit_no_bus_R2");
   // R4: read-exclusive only serves a write
   assert property (@(posedge clk) disable iff (!rst_n) bus_cmd == BC_READX |-> cpu_we)
      else $error("assert_rdx_for_write_R4");
   // R4: a stalled request is not done in the same cycle
   assert property (@(posedge clk) disable iff (!rst_n) cpu_stall |-> !cpu_done)
      else $error("assert_stall_not_done_R4");
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
   import snoop_coh_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LINES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_hit,
   output logic              cpu_stall,
   output logic              cpu_done,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_shared_in,
   input  logic              snoop_valid,
   input  logic [1:0]        snoop_cmd,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              snoop_shared_out
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0] cpu_tag, snp_tag;
   logic [TAG_W-1:0] a_tag, b_tag;
   line_st_e         a_st, b_st;
   logic             fill_en, snp_upd;
   line_st_e         fill_st, snp_st;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx = snoop_addr[IDX_W-1:0];
   assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

   snoop_coh_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (fill_en),
      .fill_idx (cpu_idx),
      .fill_tag (cpu_tag),
      .fill_st  (fill_st),
      .snp_en   (snp_upd),
      .snp_idx  (snp_idx),
      .snp_st   (snp_st),
      .rd_a_idx (cpu_idx),
      .rd_a_tag (a_tag),
      .rd_a_st  (a_st),
      .rd_b_idx (snp_idx),
      .rd_b_tag (b_tag),
      .rd_b_st  (b_st)
   );

   snoop_coh_req #(.TAG_W(TAG_W)) u_req (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_tag       (cpu_tag),
      .line_tag      (a_tag),
      .line_st       (a_st),
      .bus_gnt       (bus_gnt),
      .bus_shared_in (bus_shared_in),
      .cpu_hit       (cpu_hit),
      .cpu_stall     (cpu_stall),
      .cpu_done      (cpu_done),
      .bus_req       (bus_req),
      .bus_cmd       (bus_cmd),
      .fill_en       (fill_en),
      .fill_st       (fill_st)
   );

   snoop_coh_snoop #(.TAG_W(TAG_W)) u_snoop (
      .clk         (clk),
      .rst_n       (rst_n),
      .snoop_valid (snoop_valid),
      .snoop_cmd   (snoop_cmd),
      .snoop_tag   (snp_tag),
      .line_tag    (b_tag),
      .line_st     (b_st),
      .upd_en      (snp_upd),
      .upd_st      (snp_st),
      .shared_resp (snoop_shared_out)
   );

   assign bus_addr = (bus_cmd != BC_IDLE) ? cpu_addr : '0;

   // R4 / R5: the issued address is the request address
   assert property (@(posedge clk) disable iff (!rst_n) bus_cmd != BC_IDLE |-> bus_addr == cpu_addr && cpu_req)
      else $error("assert_bus_addr_R4");
   // R4: after a read-exclusive the same request would now hit as a write
   assert property (@(posedge clk) disable iff (!rst_n)
                    bus_cmd == BC_READX && !(snoop_valid && snp_idx == cpu_idx)
                    |=> (a_st == LN_EXCL || cpu_addr != $past(cpu_addr)))
      else $error("assert_upgrade_excl_R4");
endmodule

// File: tb/snoop_coh_ctrl_bench.sv
module snoop_coh_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic cpu_hit, cpu_stall, cpu_done, bus_req;
   logic bus_gnt = 1'b0;
   logic [1:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic bus_shared_in = 1'b0;
   logic snoop_valid = 1'b0;
   logic [1:0] snoop_cmd = 2'd0;
   logic [AW-1:0] snoop_addr = '0;
   logic snoop_shared_out;

   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   snoop_coh_ctrl #(.ADDR_W(AW), .LINES(16)) u_snoop_coh_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .cpu_done(cpu_done), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_shared_in(bus_shared_in),
      .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
      .snoop_shared_out(snoop_shared_out)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // processor access: hit expected, or miss with grant after dly cycles
   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input bit shin, input int dly,
                         input bit exp_hit, input int exp_cmd, input string rq);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
      #1;
      chk(cpu_hit == exp_hit, rq, "cpu_hit", cpu_hit, exp_hit);
      if (exp_hit) begin
         chk(cpu_done && !cpu_stall && !bus_req && bus_cmd == 2'd0, rq, "hit done/no bus",
             {cpu_done, cpu_stall, bus_req}, 3'b100);
      end else begin
         chk(cpu_stall && !cpu_done, rq, "miss stall", cpu_stall, 1);
         for (int k = 0; k < dly; k++) begin
            @(negedge clk); #1;
            chk(bus_req && cpu_stall && bus_cmd == 2'd0, rq, "waiting", {bus_req, cpu_stall, bus_cmd}, 4'b1100);
         end
         @(negedge clk);
         bus_gnt = 1'b1; bus_shared_in = shin;
         #1;
         chk(bus_req == 1'b1, rq, "bus_req", bus_req, 1);
         chk(bus_cmd == 2'(exp_cmd), rq, "bus_cmd", bus_cmd, exp_cmd);
         chk(bus_addr == a, rq, "bus_addr", bus_addr, a);
         chk(cpu_done && !cpu_stall, rq, "grant done", cpu_done, 1);
      end
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0; bus_gnt = 1'b0; bus_shared_in = 1'b0;
   endtask

   task automatic snoop_op(input logic [1:0] c, input logic [AW-1:0] a, input bit exp_sh, input string rq);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
      #1;
      chk(snoop_shared_out == exp_sh, rq, "snoop_shared_out", snoop_shared_out, exp_sh);
      @(negedge clk);
      snoop_valid = 1'b0; snoop_cmd = 2'd0;
   endtask

   // [23:20] req, [19] kind(1=snoop), [18:17] we/cmd, [16:7] addr, [6] shin,
   // [5:4] grant delay, [3] exp hit, [2:1] exp bus cmd, [0] exp shared response
   localparam int NV = 17;
   localparam logic [23:0] VEC [NV] = '{
      {4'd5,  1'b0, 2'd0, 10'h013, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0}, // R5 read miss -> E
      {4'd2,  1'b0, 2'd0, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}, // R2 read hit E
      {4'd3,  1'b0, 2'd1, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}, // R3 write hit E
      {4'd6,  1'b1, 2'd1, 10'h013, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1}, // R6 snoop read E -> S
      {4'd2,  1'b0, 2'd0, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}, // R2 read hit S
      {4'd4,  1'b0, 2'd1, 10'h013, 1'b0, 2'd2, 1'b0, 2'd2, 1'b0}, // R4 write on S -> RdX
      {4'd4,  1'b0, 2'd1, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}, // R4 now exclusive
      {4'd7,  1'b1, 2'd2, 10'h013, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R7 snoop RdX -> absent
      {4'd5,  1'b0, 2'd0, 10'h013, 1'b1, 2'd0, 1'b0, 2'd1, 1'b0}, // R5 read miss shared -> S
      {4'd6,  1'b1, 2'd1, 10'h013, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1}, // R6 snoop read S
      {4'd5,  1'b0, 2'd1, 10'h013, 1'b0, 2'd1, 1'b0, 2'd2, 1'b0}, // R5 S fill: write misses
      {4'd8,  1'b1, 2'd1, 10'h053, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R8 tag mismatch
      {4'd8,  1'b0, 2'd1, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}, // R8 line still E
      {4'd11, 1'b0, 2'd0, 10'h053, 1'b0, 2'd0, 1'b0, 2'd1, 1'b0}, // R11 conflicting fill
      {4'd11, 1'b0, 2'd0, 10'h013, 1'b1, 2'd0, 1'b0, 2'd1, 1'b0}, // R11 evicted line misses
      {4'd8,  1'b1, 2'd2, 10'h024, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0}, // R8 snoop on absent line
      {4'd2,  1'b0, 2'd0, 10'h013, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0}  // R2 hit after refill
   };

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!cpu_stall && !cpu_done && !bus_req && bus_cmd == 2'd0 && !snoop_shared_out,
          "R1", "outputs in reset", {cpu_stall, cpu_done, bus_req}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         string rq;
         rq = $sformatf("R%0d", VEC[v][23:20]);
         if (VEC[v][19])
            snoop_op(VEC[v][18:17], VEC[v][16:7], VEC[v][0], rq);
         else
            cpu_op(VEC[v][17], VEC[v][16:7], VEC[v][6], int'(VEC[v][5:4]),
                   VEC[v][3], int'(VEC[v][2:1]), rq);
      end

      // R9: snoop serviced while a miss waits for grant (0x013 is shared now)
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h035;
      @(negedge clk);
      snoop_valid = 1'b1; snoop_cmd = 2'd1; snoop_addr = 10'h013;
      #1;
      chk(bus_req && cpu_stall, "R9", "waiting", bus_req, 1);
      chk(snoop_shared_out == 1'b1, "R9", "shared response while stalled", snoop_shared_out, 1);
      @(negedge clk);
      snoop_cmd = 2'd2;
      #1;
      chk(snoop_shared_out == 1'b0, "R9", "RdX while stalled", snoop_shared_out, 0);
      @(negedge clk);
      snoop_valid = 1'b0; snoop_cmd = 2'd0; bus_gnt = 1'b1;
      #1;
      chk(bus_cmd == 2'd1 && cpu_done, "R9", "grant after snoops", bus_cmd, 1);
      @(negedge clk);
      cpu_req = 1'b0; bus_gnt = 1'b0;
      cpu_op(1'b0, 10'h013, 1'b0, 0, 1'b0, 1, "R9"); // invalidated during wait
      cpu_op(1'b0, 10'h035, 1'b0, 0, 1'b1, 0, "R9"); // fill landed

      // R1: reset clears previously filled lines
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cpu_op(1'b0, 10'h035, 1'b0, 0, 1'b0, 1, "R1");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule